// File: doc/BRIEF.md
# Fractional Q-Format Multiply Unit

This block is the signed fractional multiplier of a 32-bit DSP-style datapath. Each accepted operation takes two 32-bit operands, a one-bit fractional doubling shift and a 4-bit form select. It returns a registered result one clock after the request. The result is a single 32-bit word, or a low/high word pair for the 64-bit forms. Four status bits come with it: an overflow bit, an advance-overflow bit, and a sticky copy of each.

Operands are treated as signed fractions. Several forms take a single halfword of an operand: that halfword is sign-extended before the multiply. When the doubling shift is on, -1.0 times -1.0 cannot be represented. Each form handles that case its own way: the 32x32 and 32x16 forms flag overflow, the 16x16 forms saturate, and the rounded forms substitute a corrected value. The unit holds no operand registers and does no instruction decode. It is fed straight from a register-read stage.

Top module: `qmul_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero on that edge, including `out_valid` and both sticky bits.
- R2: `out_valid` equals the value `in_valid` had at the previous clock edge. When `in_valid` was low, `res_lo`, `res_hi`, `flag_v` and `flag_av` keep their previous values.
- R3: Form code 0 (32x32, word result) returns bits 63:32 of the signed 64-bit product, after a left shift by one when `shift_n`=1. The result goes on `res_lo`, and `res_hi` is zero. Form code 1 (32x32, pair result) returns the whole shifted product, with bits 31:0 on `res_lo` and bits 63:32 on `res_hi`.
- R4: Forms 2 and 3 multiply `opa` by sign-extended `opb[15:0]`. Forms 4 and 5 multiply `opa` by sign-extended `opb[31:16]`. The even codes return bits 47:16 of the shifted product on `res_lo`, with `res_hi` zero. The odd codes return the full shifted 64-bit product as a pair, like code 1.
- R5: For codes 0 to 5, `flag_v` is 1 exactly when `shift_n`=1 and the result word equals 0x80000000. For the pair codes, the result word is `res_hi`. For every other code, `flag_v` is 0.
- R6: Code 6 multiplies sign-extended `opa[15:0]` by sign-extended `opb[15:0]`. Code 7 multiplies sign-extended `opa[31:16]` by sign-extended `opb[31:16]`. The product is shifted by `shift_n` and returned on `res_lo`. A shifted value of 0x80000000 is replaced by 0x7FFFFFFF.
- R7: Codes 8 (lower halfwords) and 9 (upper halfwords) form the shifted 16x16 product and then add 0x8000. A sum of 0x80008000 is replaced by 0x7FFF7FFF. `res_lo` carries bits 31:16 of the value, with bits 15:0 zero, and `res_hi` is zero.
- R8: `flag_av` is bit 31 XOR bit 30 of the result word. That word is `res_hi` for the pair codes. For codes 8 and 9 it is the corrected sum before its low half is cleared.
- R9: On every clock edge, `flag_sv` takes the OR of its held value and the accepted operation's `flag_v`. `flag_sav` does the same with `flag_av`. When `clr_sticky` is high, the held value is taken as zero, but the same cycle's operation still contributes.
- R10: Codes 10 to 15 give zero on `res_lo` and `res_hi` and clear `flag_v` and `flag_av`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| op_code | input | 4 | Form select, codes 0 to 9 |
| shift_n | input | 1 | Fractional doubling shift |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| clr_sticky | input | 1 | Clears the held sticky bits |
| out_valid | output | 1 | Result registered from the previous cycle |
| res_lo | output | 32 | Result word or low word of pair |
| res_hi | output | 32 | High word of pair forms, else zero |
| flag_v | output | 1 | Overflow of last operation |
| flag_sv | output | 1 | Sticky overflow |
| flag_av | output | 1 | Advance overflow of last operation |
| flag_sav | output | 1 | Sticky advance overflow |

## Verification
The hard case is the -1.0 times -1.0 product with the doubling shift on. It is the only operand pair that raises `flag_v` in codes 0 to 5, triggers saturation in codes 6 and 7, and triggers the rounding correction in codes 8 and 9. Uniformly random operands practically never produce it. The stimulus therefore draws every operand from a small pool of extreme patterns (0x80000000, 0x80008000, 0x00008000, 0x7FFFFFFF) mixed with random words, and it also steps through each form with those operands directly. A second difficulty is the sticky clear arriving in the same cycle as an overflowing operation. Random clear pulses overlap such operations often enough to cover it.

// File: rtl/qmul_pkg.sv
package qmul_pkg;

  typedef enum logic [3:0] {
    QM_FULL_W = 4'd0,
    QM_FULL_D = 4'd1,
    QM_LO_W   = 4'd2,
    QM_LO_D   = 4'd3,
    QM_HI_W   = 4'd4,
    QM_HI_D   = 4'd5,
    QM_LL     = 4'd6,
    QM_UU     = 4'd7,
    QM_RND_L  = 4'd8,
    QM_RND_U  = 4'd9
  } qmul_op_e;

  // decoded control for one operation
  typedef struct packed {
    logic known;   // a defined form
    logic full;    // 32x32 word form
    logic mid;     // 32x16 word form
    logic sat16;   // 16x16 saturating form
    logic rnd;     // 16x16 rounded form
    logic wide;    // pair result
    logic a_half;  // take a halfword of opa
    logic b_half;  // take a halfword of opb
    logic upper;   // halfword is bits [DW-1:HW]
  } qmul_ctl_t;

endpackage

// File: rtl/qmul_decode.sv
module qmul_decode
  import qmul_pkg::*;
(
  input  logic [3:0] op_code,
  output qmul_ctl_t  ctl
);

  always_comb begin
    ctl = '0;
    case (op_code)
      QM_FULL_W: begin ctl.known = 1'b1; ctl.full = 1'b1; end
      QM_FULL_D: begin ctl.known = 1'b1; ctl.full = 1'b1; ctl.wide = 1'b1; end
      QM_LO_W:   begin ctl.known = 1'b1; ctl.mid = 1'b1; ctl.b_half = 1'b1; end
      QM_LO_D:   begin ctl.known = 1'b1; ctl.mid = 1'b1; ctl.b_half = 1'b1; ctl.wide = 1'b1; end
      QM_HI_W:   begin ctl.known = 1'b1; ctl.mid = 1'b1; ctl.b_half = 1'b1; ctl.upper = 1'b1; end
      QM_HI_D:   begin
        ctl.known = 1'b1; ctl.mid = 1'b1; ctl.b_half = 1'b1; ctl.upper = 1'b1; ctl.wide = 1'b1;
      end
      QM_LL:     begin ctl.known = 1'b1; ctl.sat16 = 1'b1; ctl.a_half = 1'b1; ctl.b_half = 1'b1; end
      QM_UU:     begin
        ctl.known = 1'b1; ctl.sat16 = 1'b1; ctl.a_half = 1'b1; ctl.b_half = 1'b1; ctl.upper = 1'b1;
      end
      QM_RND_L:  begin ctl.known = 1'b1; ctl.rnd = 1'b1; ctl.a_half = 1'b1; ctl.b_half = 1'b1; end
      QM_RND_U:  begin
        ctl.known = 1'b1; ctl.rnd = 1'b1; ctl.a_half = 1'b1; ctl.b_half = 1'b1; ctl.upper = 1'b1;
      end
      default:   ctl = '0;
    endcase
  end

endmodule

// File: rtl/qmul_core.sv
module qmul_core
  import qmul_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  qmul_ctl_t       ctl,
  output logic [2*DW-1:0] prod
);

  localparam int HW = DW / 2;
  localparam int PW = 2 * DW;

  logic [DW-1:0]        src [2];
  logic [1:0]           half_sel;
  logic signed [DW-1:0] ext [2];

  assign src[0]   = opa;
  assign src[1]   = opb;
  assign half_sel = {ctl.b_half, ctl.a_half};

  // operand conditioning: whole word or a sign-extended halfword
  for (genvar g = 0; g < 2; g++) begin : g_opnd
    logic [HW-1:0] part;
    assign part   = ctl.upper ? src[g][DW-1:HW] : src[g][HW-1:0];
    assign ext[g] = half_sel[g] ? {{HW{part[HW-1]}}, part} : src[g];
  end

  // one shared signed multiplier for all forms
  assign prod = PW'(ext[0]) * PW'(ext[1]);

endmodule

// File: rtl/qmul_shape.sv
module qmul_shape
  import qmul_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2*DW-1:0] prod,
  input  logic            shift_n,
  input  qmul_ctl_t       ctl,
  output logic [DW-1:0]   res_lo,
  output logic [DW-1:0]   res_hi,
  output logic            ovf,
  output logic            aovf
);

  localparam int HW = DW / 2;
  localparam int PW = 2 * DW;
  localparam logic [DW-1:0] MIN_W   = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MAX_W   = ~MIN_W;
  localparam logic [DW-1:0] RND_ADD = DW'(1) << (HW - 1);
  localparam logic [DW-1:0] RND_HIT = MIN_W | RND_ADD;
  localparam logic [DW-1:0] RND_FIX = MAX_W & ~RND_ADD;
  localparam logic [DW-1:0] HI_MASK = {{HW{1'b1}}, {HW{1'b0}}};

  logic [PW-1:0] sp;
  logic [DW-1:0] rsum;
  logic [DW-1:0] rfix;
  logic [DW-1:0] word;

  // doubling shift is a one-bit slice select
  assign sp   = shift_n ? {prod[PW-2:0], 1'b0} : prod;
  assign rsum = sp[DW-1:0] + RND_ADD;
  assign rfix = (rsum == RND_HIT) ? RND_FIX : rsum;

  always_comb begin
    res_lo = '0;
    res_hi = '0;
    word   = '0;
    ovf    = 1'b0;
    if (ctl.known) begin
      if (ctl.wide) begin
        res_lo = sp[DW-1:0];
        res_hi = sp[PW-1:DW];
        word   = sp[PW-1:DW];
        ovf    = shift_n && (word == MIN_W);
      end else if (ctl.full) begin
        word   = sp[PW-1:DW];
        res_lo = word;
        ovf    = shift_n && (word == MIN_W);
      end else if (ctl.mid) begin
        word   = sp[DW+HW-1:HW];
        res_lo = word;
        ovf    = shift_n && (word == MIN_W);
      end else if (ctl.sat16) begin
        word   = (shift_n && (sp[DW-1:0] == MIN_W)) ? MAX_W : sp[DW-1:0];
        res_lo = word;
      end else if (ctl.rnd) begin
        word   = rfix;
        res_lo = rfix & HI_MASK;
      end
    end
  end

  assign aovf = word[DW-1] ^ word[DW-2];

endmodule

// File: rtl/qmul_unit.sv
module qmul_unit
  import qmul_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [3:0]    op_code,
  input  logic          shift_n,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          clr_sticky,
  output logic          out_valid,
  output logic [DW-1:0] res_lo,
  output logic [DW-1:0] res_hi,
  output logic          flag_v,
  output logic          flag_sv,
  output logic          flag_av,
  output logic          flag_sav
);

  localparam int PW = 2 * DW;

  qmul_ctl_t     ctl;
  logic [PW-1:0] prod;
  logic [DW-1:0] nxt_lo, nxt_hi;
  logic          nxt_v, nxt_av;
  logic          acc_v, acc_av;

  qmul_decode u_dec (
    .op_code (op_code),
    .ctl     (ctl)
  );

  qmul_core #(.DW(DW)) u_core (
    .opa  (opa),
    .opb  (opb),
    .ctl  (ctl),
    .prod (prod)
  );

  qmul_shape #(.DW(DW)) u_shape (
    .prod    (prod),
    .shift_n (shift_n),
    .ctl     (ctl),
    .res_lo  (nxt_lo),
    .res_hi  (nxt_hi),
    .ovf     (nxt_v),
    .aovf    (nxt_av)
  );

  assign acc_v  = in_valid & nxt_v;
  assign acc_av = in_valid & nxt_av;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
      flag_v    <= 1'b0;
      flag_av   <= 1'b0;
      flag_sv   <= 1'b0;
      flag_sav  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_lo  <= nxt_lo;
        res_hi  <= nxt_hi;
        flag_v  <= nxt_v;
        flag_av <= nxt_av;
      end
      flag_sv  <= (flag_sv  & ~clr_sticky) | acc_v;
      flag_sav <= (flag_sav & ~clr_sticky) | acc_av;
    end
  end

endmodule

// File: rtl/qmul_unit_chk.sv
module qmul_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [3:0]    op_code,
  input logic          shift_n,
  input logic          clr_sticky,
  input logic          out_valid,
  input logic [DW-1:0] res_lo,
  input logic [DW-1:0] res_hi,
  input logic          flag_v,
  input logic          flag_sv,
  input logic          flag_av,
  input logic          flag_sav
);

  localparam logic [DW-1:0] MIN_W = {1'b1, {(DW-1){1'b0}}};
  localparam int HW = DW / 2;

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_lo) && $stable(res_hi) && $stable(flag_v) && $stable(flag_av)));

  p_no_v_without_shift_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !shift_n) |=> !flag_v);

  p_sat_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_code == 4'd6 || op_code == 4'd7)) |=> (res_lo != MIN_W && !flag_v && res_hi == '0));

  p_round_low_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_code == 4'd8 || op_code == 4'd9)) |=> (res_lo[HW-1:0] == '0 && res_hi == '0 && !flag_v));

  p_sv_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_sv && !clr_sticky) |=> flag_sv);

  p_sav_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_sav && !clr_sticky) |=> flag_sav);

  p_sv_covers_v_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_v) |-> flag_sv);

  p_sav_covers_av_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_av) |-> flag_sav);

  p_unknown_code_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_code >= 4'd10) |=> (res_lo == '0 && res_hi == '0 && !flag_v && !flag_av));

endmodule

bind qmul_unit qmul_unit_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .op_code    (op_code),
  .shift_n    (shift_n),
  .clr_sticky (clr_sticky),
  .out_valid  (out_valid),
  .res_lo     (res_lo),
  .res_hi     (res_hi),
  .flag_v     (flag_v),
  .flag_sv    (flag_sv),
  .flag_av    (flag_av),
  .flag_sav   (flag_sav)
);

// File: tb/qmul_unit_tb.sv
`timescale 1ns/1ps
module qmul_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic        shift_n = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        clr_sticky = 1'b0;
  logic        out_valid;
  logic [31:0] res_lo, res_hi;
  logic        flag_v, flag_sv, flag_av, flag_sav;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // expected state of the outputs after the next edge
  logic        e_valid = 0;
  logic [31:0] e_lo = 0, e_hi = 0;
  logic        e_v = 0, e_av = 0, e_sv = 0, e_sav = 0;
  string       e_tag = "R1";

  always #2 clk = ~clk;

  qmul_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code), .shift_n(shift_n),
    .opa(opa), .opb(opb), .clr_sticky(clr_sticky), .out_valid(out_valid),
    .res_lo(res_lo), .res_hi(res_hi), .flag_v(flag_v), .flag_sv(flag_sv),
    .flag_av(flag_av), .flag_sav(flag_sav)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference using 64-bit integer arithmetic
  function automatic void ref_mul(input logic [3:0] op, input logic n, input logic [31:0] a, b,
                                  output logic [31:0] lo, hi, output logic v, av, output string tag);
    longint x, y, p;
    logic [63:0] q;
    logic [31:0] w;
    lo = 0; hi = 0; v = 0; av = 0; w = 0;
    x = longint'($signed(a));
    y = longint'($signed(b));
    if (op == 2 || op == 3) y = longint'($signed(b[15:0]));
    if (op == 4 || op == 5) y = longint'($signed(b[31:16]));
    if (op == 6 || op == 8) begin x = longint'($signed(a[15:0])); y = longint'($signed(b[15:0])); end
    if (op == 7 || op == 9) begin x = longint'($signed(a[31:16])); y = longint'($signed(b[31:16])); end
    p = x * y;
    q = n ? p * 64'sd2 : p;
    case (op)
      4'd0: begin lo = q[63:32]; w = lo; v = n && (w == 32'h80000000); tag = "R3"; end
      4'd1: begin lo = q[31:0]; hi = q[63:32]; w = hi; v = n && (w == 32'h80000000); tag = "R3"; end
      4'd2, 4'd4: begin lo = q[47:16]; w = lo; v = n && (w == 32'h80000000); tag = "R4"; end
      4'd3, 4'd5: begin lo = q[31:0]; hi = q[63:32]; w = hi; v = n && (w == 32'h80000000); tag = "R4"; end
      4'd6, 4'd7: begin
        w = q[31:0];
        if (w == 32'h80000000) w = 32'h7FFFFFFF;
        lo = w; tag = "R6";
      end
      4'd8, 4'd9: begin
        w = q[31:0] + 32'h00008000;
        if (w == 32'h80008000) w = 32'h7FFF7FFF;
        lo = {w[31:16], 16'h0000}; tag = "R7";
      end
      default: begin w = 0; tag = "R10"; end
    endcase
    av = w[31] ^ w[30];
  endfunction

  task automatic compare_all();
    chk("R2", "out_valid", {31'b0, out_valid}, {31'b0, e_valid});
    chk(e_tag, "res_lo", res_lo, e_lo);
    chk(e_tag, "res_hi", res_hi, e_hi);
    chk("R5", "flag_v", {31'b0, flag_v}, {31'b0, e_v});
    chk("R8", "flag_av", {31'b0, flag_av}, {31'b0, e_av});
    chk("R9", "flag_sv", {31'b0, flag_sv}, {31'b0, e_sv});
    chk("R9", "flag_sav", {31'b0, flag_sav}, {31'b0, e_sav});
  endtask

  // called at a falling edge: drive, predict, then check at the next falling edge
  task automatic step(input logic vld, input logic [3:0] op, input logic n,
                      input logic [31:0] a, b, input logic clr);
    logic [31:0] lo, hi;
    logic v, av;
    string tag;
    in_valid = vld; op_code = op; shift_n = n; opa = a; opb = b; clr_sticky = clr;
    ref_mul(op, n, a, b, lo, hi, v, av, tag);
    e_valid = vld;
    if (vld) begin
      e_lo = lo; e_hi = hi; e_v = v; e_av = av; e_tag = tag;
    end else begin
      e_tag = "R2";
    end
    e_sv  = (clr ? 1'b0 : e_sv)  | (vld & v);
    e_sav = (clr ? 1'b0 : e_sav) | (vld & av);
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [31:0] pick_word();
    case ($urandom % 7)
      0: return 32'h80000000;
      1: return 32'h80008000;
      2: return 32'h00008000;
      3: return 32'h7FFFFFFF;
      4: return 32'h40004000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    compare_all();
    rst = 1'b0;

    // directed: every defined form with the -1 x -1 operands, both shifts
    for (int op = 0; op < 10; op++) begin
      step(1, 4'(op), 1'b1, 32'h80008000, 32'h80008000, 0);   // R5 R6 R7 corner
      step(1, 4'(op), 1'b0, 32'h80008000, 32'h80008000, 0);
      step(1, 4'(op), 1'b1, 32'h80000000, 32'h80000000, 0);   // R3 full-width corner
      step(1, 4'(op), 1'b1, 32'h40004000, 32'hC0002000, 0);
      step(1, 4'(op), 1'b0, 32'h12345678, 32'hFEDC8765, 0);
    end
    // R9: clear in same cycle as an overflowing operation
    step(1, 4'd0, 1'b1, 32'h80000000, 32'h80000000, 1);
    step(1, 4'd12, 1'b1, 32'h80000000, 32'h80000000, 1);      // R10 and clear
    // R2: idle cycles hold the result
    step(0, 4'd1, 1'b1, 32'h80000000, 32'h80000000, 0);
    step(0, 4'd7, 1'b0, 32'h11111111, 32'h22222222, 0);
    // R7: rounding without correction
    step(1, 4'd8, 1'b1, 32'h00004000, 32'h00004000, 0);
    step(1, 4'd9, 1'b0, 32'h7FFF0000, 32'h7FFF0000, 0);

    // mixed stimulus over all codes
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, 4'($urandom % 16), 1'($urandom % 2),
           pick_word(), pick_word(), ($urandom % 10) == 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule